// File: doc/BRIEF.md
# Nonvolatile Write Busy Timer with Status Polling

This block stands in for the self-timed busy interval of a nonvolatile memory write. A request to program one byte, erase one sector or erase the whole chip starts it. It then counts clock cycles up to a length set separately for each of the three kinds. While that count runs, a host read does not return array data. It returns a status byte instead. The top bit of that byte is the inverse of the top bit of the byte that was last loaded. The next bit flips on every read. A host can use either bit, or a match between two reads in a row, to find out when the write has finished.

An abort pulse ends the busy interval early. When busy falls, whether the count ran out or an abort arrived, the block raises `done` for exactly one cycle. The storage array is not part of this block: its data comes in on `rd_data_in` and is passed through whenever the block is idle.

Top module: `nvm_busy_status`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `busy`, `done` and `rd_data_out` are all 0.
- R2: A start is accepted only when the block is idle and `abort` is low. `op_kind` selects the length: 2'b00 for a byte program (PROG_CYC), 2'b01 for a sector erase (SECT_CYC) and 2'b10 for a chip erase (CHIP_CYC). After an accepted start, `busy` rises on the next clock edge and stays high for exactly that many cycles.
- R3: A start with `op_kind` = 2'b11 is ignored. `busy` and `done` stay low, and reads still return array data.
- R4: `done` is high for exactly one cycle, in the first cycle in which `busy` is low after an operation.
- R5: An `abort` while busy clears `busy` at the next edge and pulses `done`. An `abort` while idle has no effect, and a start that arrives together with `abort` is not accepted.
- R6: A start request while busy is ignored, and the running operation ends at its original time.
- R7: While idle, a read strobe registers `rd_data_in` into `rd_data_out` at the clock edge. The value is held until the next strobe.
- R8: A read while busy returns, in bit 7, the inverse of `wdata_msb` as captured at the start. Bits 5 to 0 read 0.
- R9: Bit 6 of the status reads 0 on the first busy read of each operation and alternates on every busy read after that.
- R10: Once busy has ended, reads return array data again, so two reads in a row of an unchanged location return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle request to begin an operation |
| op_kind | input | 2 | Operation kind: 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| wdata_msb | input | 1 | Bit 7 of the last byte loaded for the write |
| abort | input | 1 | One-cycle request to end the busy interval |
| rd_strobe | input | 1 | Host read access |
| rd_data_in | input | DATA_W | Data from the storage array |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle pulse when busy ends |
| rd_data_out | output | DATA_W | Read byte, with status substituted while busy |

## Verification
The bench builds the block with lengths of 5, 9 and 14 cycles for program, sector erase and chip erase. This lets it check every cycle of each busy window and see exactly where `done` falls. The 14-cycle chip erase leaves room for several status reads in a row, so the toggle pattern and the inverted top bit can be observed before completion. The short program length allows a second operation within the same run, which shows the toggle starting again from 0 and a start request being ignored mid-operation.

// File: rtl/nvm_busy_pkg.sv
package nvm_busy_pkg;

  // operation kinds, encoding fixed by the requirements
  typedef enum logic [1:0] {
    OPK_PROG = 2'b00,
    OPK_SECT = 2'b01,
    OPK_CHIP = 2'b10,
    OPK_RSVD = 2'b11
  } opk_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } st_e;

endpackage

// File: rtl/nvm_dur_sel.sv
module nvm_dur_sel
  import nvm_busy_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned PROG_CYC = 5,
  parameter int unsigned SECT_CYC = 9,
  parameter int unsigned CHIP_CYC = 14
) (
  input  opk_e             kind,
  output logic [CNT_W-1:0] load_val,
  output logic             kind_ok
);

  // counter is loaded with length-1 so busy spans exactly the length
  localparam logic [CNT_W-1:0] PROG_LD = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] SECT_LD = CNT_W'(SECT_CYC - 1);
  localparam logic [CNT_W-1:0] CHIP_LD = CNT_W'(CHIP_CYC - 1);

  always_comb begin
    kind_ok  = 1'b1;
    load_val = '0;
    unique case (kind)
      OPK_PROG: load_val = PROG_LD;
      OPK_SECT: load_val = SECT_LD;
      OPK_CHIP: load_val = CHIP_LD;
      OPK_RSVD: kind_ok  = 1'b0;
    endcase
  end

endmodule

// File: rtl/nvm_busy_ctl.sv
module nvm_busy_ctl
  import nvm_busy_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic [CNT_W-1:0] load_val,
  input  logic             abort,
  output logic             busy,
  output logic             done
);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             done_q, done_d;
  logic             expire;

  assign expire = (cnt_q == '0);

  // next state
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok && !abort) begin
          st_d   = ST_BUSY;
          cnt_d  = load_val;
          cnt_en = 1'b1;
        end
      end
      ST_BUSY: begin
        if (abort || expire) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q == ST_BUSY);
  assign done = done_q;

  // R5: abort while busy ends the window at the next edge with a done pulse
  p_abort_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort |=> !busy && done);

  // R5: abort while idle leaves the block idle and silent
  p_idle_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && abort |=> !busy && !done);

  // R4: done appears only as busy falls, and lasts one cycle
  p_done_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  p_done_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: an unfinished count keeps busy high regardless of new starts
  p_keep_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !abort && !expire |=> busy);

endmodule

// File: rtl/nvm_poll_overlay.sv
module nvm_poll_overlay #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          ld_msb,
  input  logic          busy,
  input  logic          rd_strobe,
  input  logic [DW-1:0] arr_in,
  output logic [DW-1:0] rd_out
);

  localparam int unsigned MSB = DW - 1;
  localparam int unsigned TGL = DW - 2;

  logic          ld_msb_q, ld_msb_d;
  logic          tgl_q, tgl_d;
  logic          tgl_en;
  logic [DW-1:0] rd_q, rd_d;
  logic [DW-1:0] stat;

  // status byte: inverted top bit, toggle bit, remaining bits zero
  assign stat[MSB] = ~ld_msb_q;
  assign stat[TGL] = tgl_q;
  if (DW > 2) begin : g_fill
    assign stat[DW-3:0] = '0;
  end

  always_comb begin
    ld_msb_d = capture ? ld_msb : ld_msb_q;
    tgl_en   = capture || (busy && rd_strobe);
    tgl_d    = capture ? 1'b0 : ~tgl_q;
    rd_d     = busy ? stat : arr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_msb_q <= 1'b0;
      tgl_q    <= 1'b0;
      rd_q     <= '0;
    end else begin
      ld_msb_q <= ld_msb_d;
      if (tgl_en)    tgl_q <= tgl_d;
      if (rd_strobe) rd_q  <= rd_d;
    end
  end

  assign rd_out = rd_q;

  // R7: without a strobe the read byte holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_out));

  // R8: a busy read shows the inverse of the captured top bit
  p_inv_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_strobe && !capture |=> rd_out[MSB] != ld_msb_q);

  // R9: back-to-back busy reads alternate the toggle bit
  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_strobe && $past(busy && rd_strobe) |=> rd_out[TGL] != $past(rd_out[TGL]));

  if (DW > 2) begin : g_zero_chk
    // R8: unused status bits read zero
    p_zero_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rd_strobe |=> rd_out[DW-3:0] == '0);
  end

endmodule

// File: rtl/nvm_busy_status.sv
module nvm_busy_status
  import nvm_busy_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PROG_CYC = 10000,
  parameter int unsigned SECT_CYC = 1000000,
  parameter int unsigned CHIP_CYC = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic              wdata_msb,
  input  logic              abort,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] rd_data_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data_out
);

  localparam int unsigned MAX_PS  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int unsigned MAX_CYC = (MAX_PS > CHIP_CYC) ? MAX_PS : CHIP_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  opk_e             kind;
  logic [CNT_W-1:0] load_val;
  logic             kind_ok;
  logic             start_ok;

  assign kind     = opk_e'(op_kind);
  assign start_ok = op_start && kind_ok && !busy && !abort;

  nvm_dur_sel #(
    .CNT_W    (CNT_W),
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .CHIP_CYC (CHIP_CYC)
  ) u_dur_sel (
    .kind     (kind),
    .load_val (load_val),
    .kind_ok  (kind_ok)
  );

  nvm_busy_ctl #(
    .CNT_W (CNT_W)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .start_ok (start_ok),
    .load_val (load_val),
    .abort    (abort),
    .busy     (busy),
    .done     (done)
  );

  nvm_poll_overlay #(
    .DW (DATA_W)
  ) u_overlay (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .capture   (start_ok),
    .ld_msb    (wdata_msb),
    .busy      (busy),
    .rd_strobe (rd_strobe),
    .arr_in    (rd_data_in),
    .rd_out    (rd_data_out)
  );

  // R3: a reserved kind never opens a busy window
  p_rsvd_ignored_r3: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !busy && op_start && op_kind == 2'b11 |=> !busy);

  // R2: an accepted start raises busy at the next edge
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !busy && op_start && op_kind != 2'b11 && !abort |=> busy);

endmodule

// File: tb/nvm_busy_status_bench.sv
`timescale 1ns/1ps
module nvm_busy_status_bench;

  localparam int P_CYC = 5;
  localparam int S_CYC = 9;
  localparam int C_CYC = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_start, wdata_msb, abort, rd_strobe;
  logic [1:0] op_kind;
  logic [7:0] rd_data_in, rd_data_out;
  logic       busy, done;

  always #2 clk = ~clk;

  nvm_busy_status #(
    .DATA_W(8), .PROG_CYC(P_CYC), .SECT_CYC(S_CYC), .CHIP_CYC(C_CYC)
  ) u_nvm_busy_status (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .wdata_msb(wdata_msb), .abort(abort), .rd_strobe(rd_strobe),
    .rd_data_in(rd_data_in), .busy(busy), .done(done), .rd_data_out(rd_data_out)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor: one expected byte per read strobe seen at an edge
  always @(posedge clk) rd_seen <= rd_strobe;
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual=%0h expected=none (unexpected read)", rd_data_out);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {24'b0, rd_data_out}, {24'b0, e});
      end
    end
  end

  // driver tasks: entered and left at a falling edge
  task automatic do_read(string req, logic [7:0] arr, logic [7:0] exp);
    rd_strobe = 1'b1; rd_data_in = arr;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic start_op(logic [1:0] k, logic msb);
    op_start = 1'b1; op_kind = k; wdata_msb = msb;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic run_window(string req, int dur, int k0);
    for (int k = k0; k <= dur; k++) begin
      chk(req, {31'b0, busy}, 1);
      chk(req, {31'b0, done}, 0);
      @(negedge clk);
    end
    chk(req, {31'b0, busy}, 0);
    chk("R4", {31'b0, done}, 1);
    @(negedge clk);
    chk("R4", {31'b0, done}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_start = 1'b0; op_kind = 2'b00; wdata_msb = 1'b0;
    abort = 1'b0; rd_strobe = 1'b0; rd_data_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, busy}, 0);
    chk("R1", {31'b0, done}, 0);
    chk("R1", {24'b0, rd_data_out}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {31'b0, busy}, 0);

    // R7: idle pass-through and hold
    do_read("R7", 8'h5A, 8'h5A);
    rd_data_in = 8'h11;
    repeat (2) @(negedge clk);
    chk("R7", {24'b0, rd_data_out}, 8'h5A);

    // R2: each kind runs for its own length
    start_op(2'b00, 1'b1);
    run_window("R2", P_CYC, 1);
    start_op(2'b01, 1'b0);
    run_window("R2", S_CYC, 1);

    // R8 R9: status reads during a chip erase, captured top bit 0
    start_op(2'b10, 1'b0);
    do_read("R8", 8'h3C, 8'h80);
    do_read("R9", 8'h3C, 8'hC0);
    do_read("R9", 8'h3C, 8'h80);
    run_window("R2", C_CYC, 4);

    // R9: toggle restarts at 0, top bit 1 captured
    start_op(2'b00, 1'b1);
    do_read("R9", 8'hFF, 8'h00);
    do_read("R9", 8'hFF, 8'h40);
    run_window("R2", P_CYC, 3);

    // R10: array data after completion, two equal reads
    do_read("R10", 8'hA7, 8'hA7);
    do_read("R10", 8'hA7, 8'hA7);

    // R3: reserved kind ignored
    start_op(2'b11, 1'b1);
    for (int i = 0; i < 3; i++) begin
      chk("R3", {31'b0, busy}, 0);
      chk("R3", {31'b0, done}, 0);
      @(negedge clk);
    end
    do_read("R3", 8'h66, 8'h66);

    // R5: abort during a sector erase
    start_op(2'b01, 1'b1);
    repeat (2) @(negedge clk);
    chk("R5", {31'b0, busy}, 1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R5", {31'b0, busy}, 0);
    chk("R5", {31'b0, done}, 1);
    @(negedge clk);
    chk("R5", {31'b0, done}, 0);
    do_read("R5", 8'h24, 8'h24);

    // R5: abort while idle
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R5", {31'b0, busy}, 0);
    chk("R5", {31'b0, done}, 0);
    @(negedge clk);
    chk("R5", {31'b0, done}, 0);

    // R5: start together with abort is refused
    op_start = 1'b1; op_kind = 2'b10; abort = 1'b1;
    @(negedge clk);
    op_start = 1'b0; abort = 1'b0;
    chk("R5", {31'b0, busy}, 0);
    @(negedge clk);
    chk("R5", {31'b0, done}, 0);

    // R6: second start during a program is ignored
    start_op(2'b00, 1'b0);
    op_start = 1'b1; op_kind = 2'b10;
    @(negedge clk);
    op_start = 1'b0;
    run_window("R6", P_CYC, 2);

    repeat (2) @(negedge clk);
    chk("R7", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule